// File: doc/BRIEF.md
# Fully Parallel Min-Sum LDPC Decoder

This block corrects errors in a 12-bit block code. Each 12-bit frame arrives as soft channel values: one signed 5-bit log-likelihood per bit, where a negative value leans toward bit 1. A fixed 6x12 parity-check matrix defines the code. Its six check nodes and twelve variable nodes are hard-wired to each other along the edges of that matrix, so every message on every edge is computed at the same time.

The decoder alternates between two phases. In the variable phase each bit node sums its channel value with the corrections from its checks and sends extrinsic messages back. In the check phase each check node replies with min-sum corrections. After every variable phase the block takes hard decisions and computes the syndrome. It stops with a success verdict when the syndrome is zero. When it reaches a parameterised iteration limit first, it stops with a failure verdict and reports the last hard decision.

A frame is supplied with a one-cycle start pulse. The result comes back with a one-cycle done pulse, together with the decoded word, the verdict and the number of iterations used.

Top module: `ldpc_minsum_dec`

## Requirements
- R1: After reset, done, ok and fail are low, and word_out and iters_out are zero.
- R2: The parity-check matrix has these rows, listed by 0-based bit index: check 0 {2,3,7,9}, check 1 {0,4,8,10}, check 2 {1,5,6,11}, check 3 {1,3,8,11}, check 4 {0,5,7,10}, check 5 {2,4,6,9}. Bit c of word_out is variable c.
- R3: Decoding starts with all check-to-bit corrections at zero. An input whose hard decision already satisfies every check therefore finishes after one iteration, and that hard decision is the output.
- R4: A bit's total is its channel value plus the corrections from its two checks. The message it sends on an edge is that total minus the correction received on the same edge, clipped to the range -15..+15.
- R5: A check's reply on an edge has the smallest magnitude among its other three incoming messages. Its sign is negative when an odd number of those three are negative, and a zero message counts as non-negative.
- R6: The hard decision of a bit is 1 when its total is negative and 0 when the total is zero or positive.
- R7: When the syndrome of the hard decision is zero, the block raises done with ok=1 and fail=0, outputs that decision, and sets iters_out to the number of iterations run.
- R8: When MAX_ITER iterations finish with a nonzero syndrome, the block raises done with ok=0 and fail=1 and sets iters_out to MAX_ITER. word_out carries the last hard decision.
- R9: Each iteration takes two cycles. If start is sampled at clock edge e, done is high right after edge e+2N, where N is iters_out.
- R10: A start pulse that arrives while a frame is being decoded is ignored. It changes neither the current result nor produces a second done.
- R11: done lasts one cycle. word_out and iters_out hold their values until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin decoding llr_in (only accepted when idle) |
| llr_in | input | 60 | Twelve 5-bit two's-complement channel values, bit c at [5c+4:5c] |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Last decode ended with zero syndrome |
| fail | output | 1 | Last decode hit the iteration limit |
| word_out | output | 12 | Decoded hard decision |
| iters_out | output | 5 | Iterations used by the last decode |

## Verification
All-zero inputs show that a zero total decides bit 0. All -1 inputs show that every row has even weight, so the all-ones word is accepted at once. A valid nonzero codeword sent with no noise must come back unchanged after one iteration. A codeword with one weak flipped bit must be corrected in exactly two iterations. That last case separates a working min-sum update from a stuck one, and a second instance with a one-iteration limit uses the same input to show the failure verdict. Mixed noisy codewords and fully random inputs are compared against a behavioural model of the algorithm. The comparison covers the word, the verdict, the iteration count and the latency, which exercises clipping and non-converging frames.

// File: rtl/ldpc_minsum_dec.sv
module ldpc_minsum_dec #(
  parameter int NV = 12,
  parameter int NC = 6,
  parameter int LW = 5,
  parameter int ZW = 7,
  parameter int MAX_ITER = 16,
  parameter logic [NC*NV-1:0] HMAT = 72'h254_4A1_90A_862_511_28C
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic [NV*LW-1:0]                llr_in,
  output logic                            done,
  output logic                            ok,
  output logic                            fail,
  output logic [NV-1:0]                   word_out,
  output logic [$clog2(MAX_ITER+1)-1:0]   iters_out
);
  localparam int ITW  = $clog2(MAX_ITER+1);
  localparam int MAXM = (1 << (LW-1)) - 1;
  localparam logic signed [ZW:0] PMAX = (ZW+1)'(MAXM);
  localparam logic signed [ZW:0] NMAX = -(ZW+1)'(MAXM);

  typedef enum logic [1:0] {S_IDLE, S_VAR, S_CHK} st_t;

  st_t state;
  logic signed [LW-1:0] lam   [NV];
  logic signed [LW-1:0] alpha [NC][NV];
  logic signed [LW-1:0] beta  [NC][NV];
  logic signed [ZW-1:0] z     [NV];
  logic [ITW-1:0] iter;

  logic signed [ZW:0]   z_n     [NV];
  logic signed [LW-1:0] beta_n  [NC][NV];
  logic signed [LW-1:0] alpha_n [NC][NV];
  logic [NV-1:0] hd;
  logic [NC-1:0] syn, out_syn;

  function automatic logic signed [ZW:0] ext(input logic signed [LW-1:0] v);
    return {{(ZW+1-LW){v[LW-1]}}, v};
  endfunction

  always_comb begin
    for (int c = 0; c < NV; c++) begin
      z_n[c] = ext(lam[c]);
      for (int r = 0; r < NC; r++)
        if (HMAT[r*NV+c]) z_n[c] = z_n[c] + ext(alpha[r][c]);
    end
    for (int r = 0; r < NC; r++)
      for (int c = 0; c < NV; c++) begin
        logic signed [ZW:0] d;
        d = z_n[c] - ext(alpha[r][c]);
        if (d > PMAX)      beta_n[r][c] = LW'(MAXM);
        else if (d < NMAX) beta_n[r][c] = -LW'(MAXM);
        else               beta_n[r][c] = d[LW-1:0];
      end
  end

  always_comb begin
    for (int r = 0; r < NC; r++)
      for (int c = 0; c < NV; c++) begin
        logic sgn;
        logic [LW-1:0] mag, m;
        sgn = 1'b0;
        mag = LW'(MAXM);
        for (int k = 0; k < NV; k++)
          if (HMAT[r*NV+k] && k != c) begin
            sgn = sgn ^ beta[r][k][LW-1];
            m = beta[r][k][LW-1] ? -beta[r][k] : beta[r][k];
            if (m < mag) mag = m;
          end
        alpha_n[r][c] = sgn ? -mag : mag;
      end
  end

  always_comb begin
    for (int c = 0; c < NV; c++) hd[c] = z[c][ZW-1];
    for (int r = 0; r < NC; r++) begin
      syn[r]     = ^(HMAT[r*NV +: NV] & hd);
      out_syn[r] = ^(HMAT[r*NV +: NV] & word_out);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      done <= 1'b0; ok <= 1'b0; fail <= 1'b0;
      word_out <= '0; iters_out <= '0; iter <= '0;
      for (int c = 0; c < NV; c++) begin
        lam[c] <= '0;
        z[c] <= '0;
      end
      for (int r = 0; r < NC; r++)
        for (int c = 0; c < NV; c++) begin
          alpha[r][c] <= '0;
          beta[r][c] <= '0;
        end
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          for (int c = 0; c < NV; c++) lam[c] <= llr_in[c*LW +: LW];
          for (int r = 0; r < NC; r++)
            for (int c = 0; c < NV; c++) alpha[r][c] <= '0;
          iter <= '0;
          state <= S_VAR;
        end
        S_VAR: begin
          for (int c = 0; c < NV; c++) z[c] <= z_n[c][ZW-1:0];
          beta <= beta_n;
          state <= S_CHK;
        end
        S_CHK: begin
          iter <= iter + 1'b1;
          if (syn == '0 || iter + 1'b1 == ITW'(MAX_ITER)) begin
            done <= 1'b1;
            ok <= (syn == '0);
            fail <= (syn != '0);
            word_out <= hd;
            iters_out <= iter + 1'b1;
            state <= S_IDLE;
          end else begin
            alpha <= alpha_n;
            state <= S_VAR;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(word_out) && $stable(iters_out)));
  assert_verdict_R7: assert property (@(posedge clk) disable iff (!rst_n) done |-> (ok != fail));
  assert_success_syndrome_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ok) |-> (out_syn == '0));
  assert_fail_at_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fail) |-> (iters_out == ITW'(MAX_ITER)));
  assert_phase_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_VAR) |=> (state == S_CHK));
  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |=> $stable(lam[0]) && $stable(lam[NV-1]));
endmodule

// File: tb/tb_ldpc_minsum_dec.sv
module tb_ldpc_minsum_dec;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [59:0] llr = '0;
  logic done, ok, fail;
  logic [11:0] word;
  logic [4:0] iters;
  logic d1_done, d1_ok, d1_fail;
  logic [11:0] d1_word;
  logic [0:0] d1_iters;

  ldpc_minsum_dec dut (.clk(clk), .rst_n(rst_n), .start(start), .llr_in(llr),
    .done(done), .ok(ok), .fail(fail), .word_out(word), .iters_out(iters));
  ldpc_minsum_dec #(.MAX_ITER(1)) dut_lim (.clk(clk), .rst_n(rst_n), .start(start), .llr_in(llr),
    .done(d1_done), .ok(d1_ok), .fail(d1_fail), .word_out(d1_word), .iters_out(d1_iters));

  always #5ns clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  int rows [6][4] = '{'{2,3,7,9}, '{0,4,8,10}, '{1,5,6,11}, '{1,3,8,11}, '{0,5,7,10}, '{2,4,6,9}};
  int lv [12];
  int cw [4];
  int ncw = 0;
  logic [31:0] rs = 32'h1234_5678;
  int r_w, r_ok, r_fl, r_it, r_lat, l_w, l_ok, l_fl, l_it;

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd();
    rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
    return int'(rs & 32'h7fff_ffff);
  endfunction

  function automatic int synd(input int w);
    int s = 0;
    for (int r = 0; r < 6; r++) begin
      int p = 0;
      for (int k = 0; k < 4; k++) p ^= (w >> rows[r][k]) & 1;
      s |= p << r;
    end
    return s;
  endfunction

  task automatic model(input int maxit, output int w, output int okv, output int itv);
    int a [6][12];
    int b [6][4];
    int z [12];
    for (int r = 0; r < 6; r++) for (int c = 0; c < 12; c++) a[r][c] = 0;
    okv = 0; itv = maxit; w = 0;
    for (int it = 1; it <= maxit; it++) begin
      for (int c = 0; c < 12; c++) z[c] = lv[c];
      for (int r = 0; r < 6; r++) for (int k = 0; k < 4; k++) z[rows[r][k]] += a[r][rows[r][k]];
      w = 0;
      for (int c = 0; c < 12; c++) if (z[c] < 0) w |= 1 << c;
      if (synd(w) == 0) begin okv = 1; itv = it; return; end
      if (it == maxit) return;
      for (int r = 0; r < 6; r++) for (int k = 0; k < 4; k++) begin
        int d = z[rows[r][k]] - a[r][rows[r][k]];
        b[r][k] = d > 15 ? 15 : (d < -15 ? -15 : d);
      end
      for (int r = 0; r < 6; r++) for (int k = 0; k < 4; k++) begin
        int neg = 0, mn = 15;
        for (int k2 = 0; k2 < 4; k2++) if (k2 != k) begin
          int m = b[r][k2] < 0 ? -b[r][k2] : b[r][k2];
          if (b[r][k2] < 0) neg ^= 1;
          if (m < mn) mn = m;
        end
        a[r][rows[r][k]] = neg ? -mn : mn;
      end
    end
  endtask

  task automatic run(input int busy_at);
    l_w = -1; l_ok = -1; l_fl = -1; l_it = -1;
    @(negedge clk);
    for (int c = 0; c < 12; c++) llr[c*5 +: 5] = lv[c][4:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    r_lat = 0;
    while (!done && r_lat < 200) begin
      if (d1_done) begin l_w = d1_word; l_ok = d1_ok; l_fl = d1_fail; l_it = d1_iters; end
      if (r_lat == busy_at) begin llr = {12{5'b11000}}; start = 1'b1; end
      else start = 1'b0;
      @(negedge clk);
      r_lat++;
    end
    start = 1'b0;
    if (d1_done) begin l_w = d1_word; l_ok = d1_ok; l_fl = d1_fail; l_it = d1_iters; end
    chk(done === 1'b1, "R9 done seen", r_lat, 0);
    r_w = word; r_ok = ok; r_fl = fail; r_it = iters;
  endtask

  task automatic t_reset;
    chk(done === 1'b0 && ok === 1'b0 && fail === 1'b0, "R1 flags", {done, ok, fail}, 0);
    chk(word === 12'd0 && iters === 5'd0, "R1 data", word, 0);
  endtask

  task automatic t_zero_llr;
    for (int c = 0; c < 12; c++) lv[c] = 0;
    run(-1);
    chk(r_w == 0, "R6 zero total gives 0", r_w, 0);
    chk(r_ok == 1 && r_fl == 0 && r_it == 1, "R3 R7 one iteration", r_it, 1);
    chk(r_lat == 2, "R9 latency one iteration", r_lat, 2);
  endtask

  task automatic t_all_neg;
    for (int c = 0; c < 12; c++) lv[c] = -1;
    run(-1);
    chk(r_w == 12'hFFF && r_ok == 1 && r_it == 1, "R2 R6 all ones accepted", r_w, 12'hFFF);
  endtask

  task automatic t_codeword;
    for (int c = 0; c < 12; c++) lv[c] = ((cw[0] >> c) & 1) ? -7 : 7;
    run(-1);
    chk(r_w == cw[0], "R3 clean codeword", r_w, cw[0]);
    chk(r_it == 1 && r_ok == 1, "R7 clean codeword iterations", r_it, 1);
  endtask

  task automatic t_single_err;
    for (int c = 0; c < 12; c++) lv[c] = 10;
    lv[0] = -3;
    run(-1);
    chk(r_w == 0 && r_ok == 1 && r_fl == 0, "R4 R5 weak flipped bit corrected", r_w, 0);
    chk(r_it == 2, "R7 corrected in two iterations", r_it, 2);
    chk(r_lat == 4, "R9 latency two iterations", r_lat, 4);
    chk(l_fl == 1 && l_ok == 0 && l_it == 1, "R8 limit reached fails", l_fl, 1);
    chk(l_w == 1, "R8 last hard decision output", l_w, 1);
    @(negedge clk);
    chk(done === 1'b0, "R11 done one cycle", done, 0);
    chk(word === 12'd0 && iters === 5'd2, "R11 outputs held", word, 0);
  endtask

  task automatic t_busy;
    for (int c = 0; c < 12; c++) lv[c] = 10;
    lv[0] = -3;
    run(1);
    chk(r_w == 0 && r_it == 2 && r_lat == 4, "R10 start while busy ignored", r_w, 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(done === 1'b0, "R10 no second done", done, 0);
    end
  endtask

  task automatic t_model;
    for (int i = 0; i < 24; i++) begin
      int ew, eok, eit;
      for (int c = 0; c < 12; c++) begin
        if (i % 2 == 0) begin
          int mg = 1 + rnd() % 9;
          lv[c] = ((cw[i % ncw] >> c) & 1) ? -mg : mg;
          if (rnd() % 5 == 0) lv[c] = -lv[c];
        end else lv[c] = rnd() % 32 - 16;
      end
      model(16, ew, eok, eit);
      run(-1);
      chk(r_w == ew, "R4 R5 model word", r_w, ew);
      chk(r_ok == eok && r_fl == 1 - eok, "R7 R8 model verdict", r_ok, eok);
      chk(r_it == eit && r_lat == 2 * eit, "R9 model iterations", r_it, eit);
    end
  endtask

  initial begin
    #2ms;
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int w = 1; w < 4096 && ncw < 4; w++)
      if (synd(w) == 0) begin cw[ncw] = w; ncw++; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_llr();
    t_all_neg();
    t_codeword();
    t_single_err();
    t_busy();
    t_model();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule